// File: doc/BRIEF.md
# EEPROM Page-Write Latch and Program Timer

This block sits between a two-wire serial slave engine and a behavioural byte array. During a write transfer the engine hands it data bytes one at a time. The block stores each byte in a sixteen-entry page latch, marks that entry as loaded, and steps the low four bits of its address register. The row bits of the address never change during a write. The array is not touched until the engine reports a STOP decoded directly after an acknowledge. At that point the block copies every loaded latch entry into the addressed row and holds `busy` high for a fixed number of clock cycles, which models the self-timed programming period.

The same address register serves reads. Each read request returns the byte at the current address one cycle later and advances the address across the whole array, wrapping from the last location to 0. The address register keeps its value from one transfer to the next, so a read can continue from where the previous access stopped.

The control state machine has four states. `ST_IDLE` means no transfer is open. `ST_COLLECT` means a transfer is open and bytes may be latched. `ST_COMMIT` walks the sixteen latch entries, one per cycle, and writes the loaded ones. `ST_HOLD` waits for the program timer to expire. The transitions are:
- IDLE→COLLECT on a start.
- COLLECT→COLLECT on a repeated start, which clears the mask.
- COLLECT→IDLE on an abort, or on a valid STOP when no entry is loaded.
- COLLECT→COMMIT on a valid STOP when at least one entry is loaded.
- COMMIT→HOLD after the last latch entry.
- HOLD→IDLE when the timer reaches zero.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy`, `wr_ack` and `rd_valid` are 0 and `cur_addr` is 0.
- R2: A byte offered in COLLECT with `wp` low is accepted. Accepted means `wr_ack` is 1 in the next cycle, `cur_addr[3:0]` increments and wraps from 15 to 0, and `cur_addr[10:4]` stays unchanged.
- R3: When more than 16 bytes are sent in one transfer, a later byte replaces the earlier latch entry at the same offset, and only the last value is programmed.
- R4: A byte offered while `wp` is 1 is discarded. `wr_ack` stays 0, `cur_addr` does not change and the array is not modified.
- R5: The array changes only after `stop_after_ack`. An abort drops all latched bytes and leaves the array unchanged.
- R6: `busy` rises in the cycle after a valid STOP that has at least one latched byte, and stays high for exactly `PROG_CYCLES` cycles.
- R7: While `busy` is 1, every request is ignored. This covers address load, read, start, byte, stop and abort. `cur_addr` is held and `rd_valid` and `wr_ack` stay 0.
- R8: A program cycle writes only the latch entries loaded in the current transfer. All other bytes of the row keep their contents.
- R9: After `rd_req`, `rd_valid` is 1 in the next cycle with `rd_data` equal to the byte at the previous address. `cur_addr` then increments over all 11 bits and wraps from 0x7FF to 0x000.
- R10: A new start clears the loaded mask, so bytes latched before it are never programmed. `cur_addr` keeps its value across start and across transfers.
- R11: A valid STOP with no loaded entry starts no program cycle. `busy` stays 0 and the state returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | START seen by the serial engine; opens a transfer and clears the loaded mask |
| xfer_abort | input | 1 | Transfer ended without a valid program trigger; drops latched bytes |
| stop_after_ack | input | 1 | STOP decoded directly after an acknowledge; program trigger |
| wp | input | 1 | Write protect level; 1 discards data bytes |
| addr_load | input | 1 | Load `addr_in` into the address register |
| addr_in | input | ADDR_W | Address to load |
| byte_vld | input | 1 | Data byte strobe from the engine |
| byte_in | input | DATA_W | Data byte |
| rd_req | input | 1 | Request one read byte |
| busy | output | 1 | Program cycle in progress |
| wr_ack | output | 1 | Previous cycle's byte was accepted |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| rd_data | output | DATA_W | Byte read from the array |
| cur_addr | output | ADDR_W | Current address register |

## Verification
The hardest case to reach from the ports is the overflow of a single transfer past sixteen bytes. Reaching it needs a seventeenth byte in the same open transfer, so the offset wraps and the latch entry for offset 0 is replaced before the STOP arrives. A directed sequence loads a row base, streams seventeen bytes with distinct values and then reads back offsets 0 and 1. Requests that arrive during the program period are also hard to observe. A directed phase keeps driving address loads, reads and bytes on every busy cycle, checks at each cycle that nothing responds, and counts the busy length.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_HOLD    = 2'd3
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_addr_ctr.sv
module pgwr_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              page_inc,
    input  logic              seq_inc,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (page_inc) begin
            // offset bits wrap inside the row, row bits untouched
            addr <= {addr[ADDR_W-1:OFS_W], addr[OFS_W-1:0] + OFS_W'(1)};
        end else if (seq_inc) begin
            addr <= addr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/pgwr_page_latch.sv
module pgwr_page_latch #(
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              mask_any
);
    localparam int PAGE_N = 1 << OFS_W;

    logic [PAGE_N-1:0] loaded;
    logic [DATA_W-1:0] entry [PAGE_N];

    for (genvar g = 0; g < PAGE_N; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                loaded[g] <= 1'b0;
            end else if (clr) begin
                loaded[g] <= 1'b0;
            end else if (wr_en && (wr_idx == OFS_W'(g))) begin
                loaded[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == OFS_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    assign rd_data   = entry[rd_idx];
    assign rd_loaded = loaded[rd_idx];
    assign mask_any  = |loaded;
endmodule

// File: rtl/pgwr_prog_timer.sv
module pgwr_prog_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pgwr_mem_array.sv
module pgwr_mem_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int OFS_W       = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic              xfer_abort,
    input  logic              stop_after_ack,
    input  logic              wp,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              rd_req,
    output logic              busy,
    output logic              wr_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int ROW_W = ADDR_W - OFS_W;
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);
    localparam logic [OFS_W-1:0] LAST_IDX = '1;

    pgwr_state_e state_q, state_d;

    logic [OFS_W-1:0]  commit_idx_q;
    logic              open_ok;
    logic              take_byte;
    logic              rd_go;
    logic              ld_go;
    logic              latch_clr;
    logic              fire;
    logic              mask_any;
    logic              ent_loaded;
    logic [DATA_W-1:0] ent_data;
    logic              tmr_done;
    logic              mem_we;
    logic              wr_ack_q;
    logic              rd_valid_q;
    logic [ROW_W-1:0]  row;

    assign row = cur_addr[ADDR_W-1:OFS_W];

    // request qualification: nothing is taken outside IDLE/COLLECT
    always_comb begin
        open_ok   = (state_q == ST_IDLE) || (state_q == ST_COLLECT);
        ld_go     = open_ok && addr_load;
        latch_clr = open_ok && (xfer_start || xfer_abort);
        fire      = (state_q == ST_COLLECT) && stop_after_ack && !xfer_abort && mask_any;
        take_byte = (state_q == ST_COLLECT) && byte_vld && !wp && !addr_load
                    && !xfer_start && !xfer_abort && !stop_after_ack;
        rd_go     = open_ok && rd_req && !addr_load && !byte_vld;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start && !xfer_abort) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (xfer_abort)          state_d = ST_IDLE;
                else if (stop_after_ack) state_d = mask_any ? ST_COMMIT : ST_IDLE;
                else                     state_d = ST_COLLECT;
            end
            ST_COMMIT: begin
                if (commit_idx_q == LAST_IDX) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from the state
    always_comb begin
        busy   = 1'b0;
        mem_we = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_COLLECT: busy = 1'b0;
            ST_COMMIT: begin
                busy   = 1'b1;
                mem_we = ent_loaded;
            end
            ST_HOLD: busy = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_idx_q <= '0;
            wr_ack_q     <= 1'b0;
            rd_valid_q   <= 1'b0;
        end else begin
            wr_ack_q   <= take_byte;
            rd_valid_q <= rd_go;
            if (fire)                        commit_idx_q <= '0;
            else if (state_q == ST_COMMIT)   commit_idx_q <= commit_idx_q + OFS_W'(1);
        end
    end

    assign wr_ack   = wr_ack_q;
    assign rd_valid = rd_valid_q;

    pgwr_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_go),
        .load_val (addr_in),
        .page_inc (take_byte),
        .seq_inc  (rd_go),
        .addr     (cur_addr)
    );

    pgwr_page_latch #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (latch_clr),
        .wr_en     (take_byte),
        .wr_idx    (cur_addr[OFS_W-1:0]),
        .wr_data   (byte_in),
        .rd_idx    (commit_idx_q),
        .rd_data   (ent_data),
        .rd_loaded (ent_loaded),
        .mask_any  (mask_any)
    );

    pgwr_prog_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fire),
        .load_val (TMR_W'(PROG_CYCLES - 1)),
        .run      (busy),
        .done     (tmr_done)
    );

    pgwr_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr ({row, commit_idx_q}),
        .wdata (ent_data),
        .re    (rd_go),
        .raddr (cur_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
    parameter int ADDR_W      = 11,
    parameter int OFS_W       = 4,
    parameter int PROG_CYCLES = 625000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              wr_ack,
    input logic              rd_valid,
    input logic              wp,
    input logic              byte_vld,
    input logic              stop_after_ack,
    input logic              mask_any,
    input logic [ADDR_W-1:0] cur_addr
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R6: a STOP with latched bytes while not busy raises busy next cycle
    a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_after_ack && mask_any) |=> busy);

    // R6: busy period length equals PROG_CYCLES
    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == PROG_CYCLES));

    a_r6_busy_max: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < PROG_CYCLES));

    // R7: address frozen and no read response while busy
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cur_addr));

    a_r7_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);

    // R4: protected bytes are never acknowledged
    a_r4_wp_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && wp) |=> !wr_ack);

    // R2: an acknowledged byte stepped only the offset bits
    a_r2_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> ((cur_addr[OFS_W-1:0] == $past(cur_addr[OFS_W-1:0]) + OFS_W'(1))
                    && (cur_addr[ADDR_W-1:OFS_W] == $past(cur_addr[ADDR_W-1:OFS_W]))));

    // R9: a read response follows a full-width address step
    a_r9_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
    .ADDR_W      (ADDR_W),
    .OFS_W       (OFS_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy           (busy),
    .wr_ack         (wr_ack),
    .rd_valid       (rd_valid),
    .wp             (wp),
    .byte_vld       (byte_vld),
    .stop_after_ack (stop_after_ack),
    .mask_any       (mask_any),
    .cur_addr       (cur_addr)
);

// File: tb/pgwr_ctrl_test.sv
module pgwr_ctrl_test;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int PROG   = 40;

    localparam logic [3:0] OP_WP    = 4'd0;
    localparam logic [3:0] OP_LOAD  = 4'd1;
    localparam logic [3:0] OP_START = 4'd2;
    localparam logic [3:0] OP_BYTE  = 4'd3;
    localparam logic [3:0] OP_STOP  = 4'd4;
    localparam logic [3:0] OP_ABORT = 4'd5;
    localparam logic [3:0] OP_READ  = 4'd6;
    localparam logic [3:0] OP_ADDR  = 4'd7;

    typedef struct packed {
        logic [3:0]  op;
        logic [10:0] arg;
        logic [10:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 49;
    localparam vec_t VEC [NV] = '{
        '{OP_WP,    11'h000, 11'h000, 4'd2},
        '{OP_LOAD,  11'h125, 11'h000, 4'd2},
        '{OP_START, 11'h000, 11'h000, 4'd2},
        '{OP_BYTE,  11'h0A1, 11'h001, 4'd2},   // R2 accepted
        '{OP_ADDR,  11'h000, 11'h126, 4'd2},   // R2 offset step
        '{OP_BYTE,  11'h0A2, 11'h001, 4'd2},
        '{OP_STOP,  11'h000, 11'h001, 4'd6},   // R6 busy rises
        '{OP_LOAD,  11'h125, 11'h000, 4'd5},
        '{OP_READ,  11'h000, 11'h0A1, 4'd9},   // R9 read data
        '{OP_READ,  11'h000, 11'h0A2, 4'd9},
        '{OP_ADDR,  11'h000, 11'h127, 4'd9},
        '{OP_START, 11'h000, 11'h000, 4'd4},
        '{OP_WP,    11'h001, 11'h000, 4'd4},
        '{OP_BYTE,  11'h055, 11'h000, 4'd4},   // R4 not acked
        '{OP_ADDR,  11'h000, 11'h127, 4'd4},   // R4 address held, R10 kept over start
        '{OP_WP,    11'h000, 11'h000, 4'd4},
        '{OP_STOP,  11'h000, 11'h000, 4'd11},  // R11 empty mask, no busy
        '{OP_LOAD,  11'h127, 11'h000, 4'd4},
        '{OP_READ,  11'h000, 11'h0A2, 4'd4},   // 0x127 never written: reads stale? see directed
        '{OP_LOAD,  11'h125, 11'h000, 4'd5},
        '{OP_START, 11'h000, 11'h000, 4'd5},
        '{OP_BYTE,  11'h077, 11'h001, 4'd5},
        '{OP_ABORT, 11'h000, 11'h000, 4'd5},
        '{OP_LOAD,  11'h125, 11'h000, 4'd5},
        '{OP_READ,  11'h000, 11'h0A1, 4'd5},   // R5 abort dropped byte
        '{OP_LOAD,  11'h126, 11'h000, 4'd10},
        '{OP_START, 11'h000, 11'h000, 4'd10},
        '{OP_BYTE,  11'h088, 11'h001, 4'd10},
        '{OP_START, 11'h000, 11'h000, 4'd10},
        '{OP_BYTE,  11'h099, 11'h001, 4'd10},
        '{OP_STOP,  11'h000, 11'h001, 4'd10},
        '{OP_LOAD,  11'h126, 11'h000, 4'd10},
        '{OP_READ,  11'h000, 11'h0A2, 4'd10},  // R10 byte before restart dropped
        '{OP_READ,  11'h000, 11'h099, 4'd10},
        '{OP_LOAD,  11'h12E, 11'h000, 4'd2},
        '{OP_START, 11'h000, 11'h000, 4'd2},
        '{OP_BYTE,  11'h0B0, 11'h001, 4'd2},
        '{OP_BYTE,  11'h0B1, 11'h001, 4'd2},
        '{OP_BYTE,  11'h0B2, 11'h001, 4'd2},
        '{OP_ADDR,  11'h000, 11'h121, 4'd2},   // R2 wrap 15 -> 0, row kept
        '{OP_STOP,  11'h000, 11'h001, 4'd6},
        '{OP_LOAD,  11'h12E, 11'h000, 4'd8},
        '{OP_READ,  11'h000, 11'h0B0, 4'd8},
        '{OP_READ,  11'h000, 11'h0B1, 4'd8},
        '{OP_LOAD,  11'h120, 11'h000, 4'd8},
        '{OP_READ,  11'h000, 11'h0B2, 4'd8},
        '{OP_LOAD,  11'h125, 11'h000, 4'd8},
        '{OP_READ,  11'h000, 11'h0A1, 4'd8},   // R8 untouched entries keep contents
        '{OP_READ,  11'h000, 11'h0A2, 4'd8}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_start = 1'b0;
    logic              xfer_abort = 1'b0;
    logic              stop_after_ack = 1'b0;
    logic              wp = 1'b0;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              byte_vld = 1'b0;
    logic [DATA_W-1:0] byte_in = '0;
    logic              rd_req = 1'b0;
    logic              busy;
    logic              wr_ack;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] cur_addr;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pgwr_ctrl #(.ADDR_W(ADDR_W), .OFS_W(4), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .xfer_start     (xfer_start),
        .xfer_abort     (xfer_abort),
        .stop_after_ack (stop_after_ack),
        .wp             (wp),
        .addr_load      (addr_load),
        .addr_in        (addr_in),
        .byte_vld       (byte_vld),
        .byte_in        (byte_in),
        .rd_req         (rd_req),
        .busy           (busy),
        .wr_ack         (wr_ack),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .cur_addr       (cur_addr)
    );

    task automatic check(input bit ok, input int req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input logic [3:0] op, input logic [10:0] arg,
                           input logic [10:0] exp, input int req);
        case (op)
            OP_WP: begin
                wp = arg[0];
                @(negedge clk);
            end
            OP_LOAD: begin
                addr_load = 1'b1; addr_in = arg;
                @(negedge clk);
                addr_load = 1'b0;
            end
            OP_START: begin
                xfer_start = 1'b1;
                @(negedge clk);
                xfer_start = 1'b0;
            end
            OP_BYTE: begin
                byte_vld = 1'b1; byte_in = arg[7:0];
                @(negedge clk);
                byte_vld = 1'b0;
                check(wr_ack == exp[0], req, int'(wr_ack), int'(exp[0]));
            end
            OP_STOP: begin
                stop_after_ack = 1'b1;
                @(negedge clk);
                stop_after_ack = 1'b0;
                check(busy == exp[0], req, int'(busy), int'(exp[0]));
                while (busy) @(negedge clk);
            end
            OP_ABORT: begin
                xfer_abort = 1'b1;
                @(negedge clk);
                xfer_abort = 1'b0;
            end
            OP_READ: begin
                rd_req = 1'b1;
                @(negedge clk);
                rd_req = 1'b0;
                check(rd_valid == 1'b1, req, int'(rd_valid), 1);
                check(rd_data == exp[7:0], req, int'(rd_data), int'(exp[7:0]));
            end
            OP_ADDR: begin
                check(cur_addr == exp, req, int'(cur_addr), int'(exp));
            end
            default: ;
        endcase
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, 1, int'(busy), 0);
        check(wr_ack == 1'b0, 1, int'(wr_ack), 0);
        check(rd_valid == 1'b0, 1, int'(rd_valid), 0);
        check(cur_addr == '0, 1, int'(cur_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Preload 0x127 so that the table's read of it has a known value (R8 background)
        run_vec(OP_LOAD, 11'h127, 11'h0, 8);
        run_vec(OP_START, 11'h0, 11'h0, 8);
        run_vec(OP_BYTE, 11'h0A2, 11'h1, 8);
        run_vec(OP_STOP, 11'h0, 11'h1, 8);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i].op, VEC[i].arg, VEC[i].exp, int'(VEC[i].req));
        end

        // R6 / R7: exact busy length, requests ignored while busy
        run_vec(OP_LOAD, 11'h200, 11'h0, 6);
        run_vec(OP_START, 11'h0, 11'h0, 6);
        run_vec(OP_BYTE, 11'h0C3, 11'h1, 6);
        stop_after_ack = 1'b1;
        @(negedge clk);
        stop_after_ack = 1'b0;
        check(busy == 1'b1, 6, int'(busy), 1);
        begin
            int blen = 0;
            while (busy && blen < 1000) begin
                blen++;
                addr_load = blen[0]; addr_in = 11'h0AA;
                rd_req = ~blen[0];
                byte_vld = 1'b1; byte_in = 8'hEE;
                xfer_start = blen[1];
                @(negedge clk);
                addr_load = 1'b0; rd_req = 1'b0; byte_vld = 1'b0; xfer_start = 1'b0;
                if (busy) begin
                    check(rd_valid == 1'b0 && wr_ack == 1'b0, 7, int'({rd_valid, wr_ack}), 0);
                    check(cur_addr == 11'h201, 7, int'(cur_addr), 'h201);
                end
            end
            check(blen == PROG, 6, blen, PROG);
        end
        run_vec(OP_ADDR, 11'h0, 11'h201, 7);
        run_vec(OP_LOAD, 11'h200, 11'h0, 7);
        run_vec(OP_READ, 11'h0, 11'h0C3, 7);

        // R3: seventeen bytes overwrite offset 0
        run_vec(OP_LOAD, 11'h140, 11'h0, 3);
        run_vec(OP_START, 11'h0, 11'h0, 3);
        for (int i = 0; i < 17; i++) begin
            run_vec(OP_BYTE, 11'(8'h40 + i), 11'h1, 3);
        end
        run_vec(OP_STOP, 11'h0, 11'h1, 3);
        run_vec(OP_LOAD, 11'h140, 11'h0, 3);
        run_vec(OP_READ, 11'h0, 11'h050, 3);
        run_vec(OP_READ, 11'h0, 11'h041, 3);

        // R9: sequential read wraps over the full address space
        run_vec(OP_LOAD, 11'h7FF, 11'h0, 9);
        run_vec(OP_START, 11'h0, 11'h0, 9);
        run_vec(OP_BYTE, 11'h05A, 11'h1, 9);
        run_vec(OP_STOP, 11'h0, 11'h1, 9);
        run_vec(OP_LOAD, 11'h7FF, 11'h0, 9);
        run_vec(OP_READ, 11'h0, 11'h05A, 9);
        run_vec(OP_ADDR, 11'h0, 11'h000, 9);

        finish_run();
    end
endmodule